// File: doc/BRIEF.md
# Stride Prefetch Stream Table

The block keeps a small set of active prefetch streams for a cache controller. A training stage outside the block hands it a new stream: a base line address, a signed stride counted in cache lines, and a request type. The block picks a slot for the stream and sends out a short burst of startup prefetches at successive stride steps from the base. After that, each stream follows the demand traffic. A notification of a demand miss or a prefetch hit is compared against every live stream. When it matches, that stream moves forward by one stride and one more prefetch goes out.

Prefetch requests leave through a valid/ready port, one address per cycle. Three counters report the number of streams allocated, prefetch handshakes and page-boundary crossings. A static configuration input sets whether streams may cross a page. When crossing is not allowed, a stream that would step into another page is dropped at that step.

The table accepts a new allocation or an event only while it is idle. It holds its ready outputs low while a burst or an extension is being issued.

Top module: `pf_stream_table`

## Requirements
- R1: After reset no stream is valid (no event matches), `pf_valid` is 0, `alloc_ready` and `evt_ready` are 1, and all three counters are 0.
- R2: A new stream goes into the lowest-indexed invalid slot if one exists. Otherwise it replaces the slot with the oldest last-use time. Last-use time is set on allocation and refreshed on every matched event.
- R3: An accepted allocation with base B and stride S sends STARTUP prefetches, in order, at B+k*S for k = 1..STARTUP, all carrying the allocation's type. The stride is a two's-complement line count and addresses wrap modulo 2^ADDR_W. `cnt_alloc` rises by one per accepted allocation.
- R4: While `pf_valid` is 1 and `pf_ready` is 0, `pf_line` and `pf_type` hold steady and no request is counted. `cnt_req` rises by exactly one per cycle with `pf_valid` and `pf_ready` both 1.
- R5: An event line L matches a valid stream with current address A and stride S when L = A - j*S for some j in 0..STARTUP-1. `evt_match` shows this in the same cycle as an accepted event. j = STARTUP does not match.
- R6: A matched event of either kind (kind 0 = prefetch hit, kind 1 = demand miss) issues exactly one prefetch at A+S of the matched stream. A+S then becomes the stream's new current address.
- R7: `miss_to_train` is 1 only for an accepted event of kind 1 that matches no stream. A prefetch-hit event never raises it.
- R8: The page of a line is its address shifted right by PAGE_BITS. When a step moves into a different page than the stream's current address and `cross_en` is 1, `cnt_cross` rises by one and the prefetch is still issued.
- R9: When such a page-crossing step occurs with `cross_en` 0, `cnt_cross` rises by one, the stream becomes invalid, and no further prefetch of that burst is issued. Its lines no longer match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cross_en | input | 1 | Allow prefetches into a new page (static) |
| alloc_valid | input | 1 | New stream request |
| alloc_ready | output | 1 | Table idle, allocation accepted |
| alloc_line | input | ADDR_W | Base line address |
| alloc_stride | input | STRIDE_W | Signed stride in lines |
| alloc_type | input | TYPE_W | Request type carried by the stream |
| evt_valid | input | 1 | Hit or miss notification |
| evt_ready | output | 1 | Event accepted this cycle |
| evt_line | input | ADDR_W | Line address of the event |
| evt_kind | input | 1 | 0 = prefetch hit, 1 = demand miss |
| evt_match | output | 1 | Accepted event matched a stream |
| miss_to_train | output | 1 | Unmatched demand miss for the trainer |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Controller takes the request |
| pf_line | output | ADDR_W | Prefetch line address |
| pf_type | output | TYPE_W | Prefetch request type |
| cnt_alloc | output | CNT_W | Streams allocated |
| cnt_req | output | CNT_W | Prefetch handshakes |
| cnt_cross | output | CNT_W | Page crossings seen |

## Verification
A wrong victim choice does not show up at once. It appears one event later: a stream that should still be alive stops matching, `evt_match` stays low and `miss_to_train` rises. A wrong stored address or stride shows on `pf_line` at the next extension, within two cycles of the matching event. The bench compares every captured prefetch, in order, against addresses it computes itself. It also probes match windows at the edges j = STARTUP-1 and j = STARTUP, and checks slot reuse after page kills. A missed kill shows as an extra prefetch in the burst and as a stale line that still matches.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [0:0] {
    EVT_PF_HIT      = 1'b0,
    EVT_DEMAND_MISS = 1'b1
  } evt_kind_e;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } issue_state_e;
endpackage

// File: rtl/pfst_step.sv
module pfst_step #(
  parameter int ADDR_W    = 26,
  parameter int STRIDE_W  = 8,
  parameter int PAGE_BITS = 6
) (
  input  logic [ADDR_W-1:0]   cur_i,
  input  logic [STRIDE_W-1:0] stride_i,
  output logic [ADDR_W-1:0]   nxt_o,
  output logic                cross_o
);
  logic [ADDR_W-1:0] sx;
  assign sx      = {{(ADDR_W-STRIDE_W){stride_i[STRIDE_W-1]}}, stride_i};
  assign nxt_o   = cur_i + sx;
  assign cross_o = nxt_o[ADDR_W-1:PAGE_BITS] != cur_i[ADDR_W-1:PAGE_BITS];
endmodule

// File: rtl/pfst_victim.sv
module pfst_victim #(
  parameter int N     = 4,
  parameter int TS_W  = 16,
  parameter int IDX_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              valid_i,
  input  logic [N-1:0][TS_W-1:0]    ts_i,
  output logic [IDX_W-1:0]          victim_o
);
  logic            found;
  logic [TS_W-1:0] best;

  always_comb begin
    victim_o = '0;
    found    = 1'b0;
    best     = ts_i[0];
    for (int i = 0; i < N; i++) begin
      if (!found) begin
        if (!valid_i[i]) begin
          victim_o = IDX_W'(i);
          found    = 1'b1;
        end else if (ts_i[i] < best) begin
          best     = ts_i[i];
          victim_o = IDX_W'(i);
        end
      end
    end
  end

  // R2: a free slot always wins over eviction
  p_victim_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i != {N{1'b1}}) |-> !valid_i[victim_o]);
endmodule

// File: rtl/pfst_match.sv
module pfst_match #(
  parameter int N        = 4,
  parameter int ADDR_W   = 26,
  parameter int STRIDE_W = 8,
  parameter int DEPTH    = 1,
  parameter int IDX_W    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N-1:0]                  valid_i,
  input  logic [N-1:0][ADDR_W-1:0]      line_i,
  input  logic [N-1:0][STRIDE_W-1:0]    stride_i,
  input  logic [ADDR_W-1:0]             probe_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o
);
  logic [N-1:0] ent_hit;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [ADDR_W-1:0] sx;
    logic [DEPTH-1:0]  win_hit;
    assign sx = {{(ADDR_W-STRIDE_W){stride_i[i][STRIDE_W-1]}}, stride_i[i]};
    for (genvar j = 0; j < DEPTH; j++) begin : g_win
      logic [ADDR_W-1:0] cand;
      assign cand       = line_i[i] - ADDR_W'(j) * sx;
      assign win_hit[j] = cand == probe_i;
    end
    assign ent_hit[i] = valid_i[i] & (|win_hit);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!hit_o && ent_hit[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  // R5: only live streams can match
  p_match_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> valid_i[idx_o]);
endmodule

// File: rtl/pf_stream_table.sv
module pf_stream_table #(
  parameter int NSTREAMS  = 4,
  parameter int STARTUP   = 1,
  parameter int ADDR_W    = 26,
  parameter int STRIDE_W  = 8,
  parameter int PAGE_BITS = 6,
  parameter int TYPE_W    = 2,
  parameter int TS_W      = 16,
  parameter int CNT_W     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cross_en,
  input  logic                alloc_valid,
  output logic                alloc_ready,
  input  logic [ADDR_W-1:0]   alloc_line,
  input  logic [STRIDE_W-1:0] alloc_stride,
  input  logic [TYPE_W-1:0]   alloc_type,
  input  logic                evt_valid,
  output logic                evt_ready,
  input  logic [ADDR_W-1:0]   evt_line,
  input  logic                evt_kind,
  output logic                evt_match,
  output logic                miss_to_train,
  output logic                pf_valid,
  input  logic                pf_ready,
  output logic [ADDR_W-1:0]   pf_line,
  output logic [TYPE_W-1:0]   pf_type,
  output logic [CNT_W-1:0]    cnt_alloc,
  output logic [CNT_W-1:0]    cnt_req,
  output logic [CNT_W-1:0]    cnt_cross
);
  import pf_pkg::*;

  localparam int IDX_W = (NSTREAMS > 1) ? $clog2(NSTREAMS) : 1;
  localparam int RW    = $clog2(STARTUP + 1);

  // stream table
  logic [NSTREAMS-1:0]                 vld_q, vld_d;
  logic [NSTREAMS-1:0][ADDR_W-1:0]     line_q, line_d;
  logic [NSTREAMS-1:0][STRIDE_W-1:0]   strd_q, strd_d;
  logic [NSTREAMS-1:0][TS_W-1:0]       ts_q, ts_d;
  logic [NSTREAMS-1:0][TYPE_W-1:0]     typ_q, typ_d;

  // issue control
  issue_state_e     st_q, st_d;
  logic [IDX_W-1:0] tgt_q, tgt_d;
  logic [RW-1:0]    rem_q, rem_d;
  logic [TS_W-1:0]  now_q;
  logic [CNT_W-1:0] ca_q, ca_d, cr_q, cr_d, cx_q, cx_d;

  logic [IDX_W-1:0]  victim, m_idx;
  logic              m_hit;
  logic [ADDR_W-1:0] step_line;
  logic              step_cross, step_kill;
  logic              alloc_fire, evt_fire, pf_fire;

  pfst_victim #(.N(NSTREAMS), .TS_W(TS_W), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_i(vld_q), .ts_i(ts_q), .victim_o(victim));

  pfst_match #(.N(NSTREAMS), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W),
               .DEPTH(STARTUP), .IDX_W(IDX_W)) u_match (
    .clk(clk), .rst_n(rst_n), .valid_i(vld_q), .line_i(line_q),
    .stride_i(strd_q), .probe_i(evt_line), .hit_o(m_hit), .idx_o(m_idx));

  pfst_step #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .PAGE_BITS(PAGE_BITS)) u_step (
    .cur_i(line_q[tgt_q]), .stride_i(strd_q[tgt_q]),
    .nxt_o(step_line), .cross_o(step_cross));

  assign alloc_ready   = (st_q == ST_IDLE);
  assign evt_ready     = (st_q == ST_IDLE) && !alloc_valid;
  assign alloc_fire    = alloc_valid && alloc_ready;
  assign evt_fire      = evt_valid && evt_ready;
  assign evt_match     = evt_fire && m_hit;
  assign miss_to_train = evt_fire && !m_hit && (evt_kind == EVT_DEMAND_MISS);

  assign step_kill = (st_q == ST_ISSUE) && step_cross && !cross_en;
  assign pf_valid  = (st_q == ST_ISSUE) && !step_kill;
  assign pf_line   = step_line;
  assign pf_type   = typ_q[tgt_q];
  assign pf_fire   = pf_valid && pf_ready;

  assign cnt_alloc = ca_q;
  assign cnt_req   = cr_q;
  assign cnt_cross = cx_q;

  // next-state
  always_comb begin
    vld_d  = vld_q;
    line_d = line_q;
    strd_d = strd_q;
    ts_d   = ts_q;
    typ_d  = typ_q;
    st_d   = st_q;
    tgt_d  = tgt_q;
    rem_d  = rem_q;
    ca_d   = ca_q;
    cr_d   = cr_q;
    cx_d   = cx_q;
    case (st_q)
      ST_IDLE: begin
        if (alloc_fire) begin
          vld_d[victim]  = 1'b1;
          line_d[victim] = alloc_line;
          strd_d[victim] = alloc_stride;
          ts_d[victim]   = now_q;
          typ_d[victim]  = alloc_type;
          tgt_d          = victim;
          rem_d          = RW'(STARTUP);
          st_d           = ST_ISSUE;
          ca_d           = ca_q + 1'b1;
        end else if (evt_fire && m_hit) begin
          ts_d[m_idx] = now_q;
          tgt_d       = m_idx;
          rem_d       = RW'(1);
          st_d        = ST_ISSUE;
        end
      end
      default: begin
        if (step_kill) begin
          vld_d[tgt_q] = 1'b0;
          cx_d         = cx_q + 1'b1;
          st_d         = ST_IDLE;
        end else if (pf_fire) begin
          line_d[tgt_q] = step_line;
          cr_d          = cr_q + 1'b1;
          if (step_cross) cx_d = cx_q + 1'b1;
          rem_d = rem_q - 1'b1;
          if (rem_q == RW'(1)) st_d = ST_IDLE;
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      line_q <= '0;
      strd_q <= '0;
      ts_q   <= '0;
      typ_q  <= '0;
      st_q   <= ST_IDLE;
      tgt_q  <= '0;
      rem_q  <= '0;
      now_q  <= '0;
      ca_q   <= '0;
      cr_q   <= '0;
      cx_q   <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      vld_q <= vld_d;
      st_q  <= st_d;
      ca_q  <= ca_d;
      cr_q  <= cr_d;
      cx_q  <= cx_d;
      if (alloc_fire || evt_fire || pf_fire) begin
        line_q <= line_d;
        strd_q <= strd_d;
        ts_q   <= ts_d;
        typ_q  <= typ_d;
        tgt_q  <= tgt_d;
      end
      if (alloc_fire || evt_fire || pf_fire) rem_q <= rem_d;
    end
  end

  // R4: request held while stalled (cross_en is static by contract)
  p_pf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line) && $stable(pf_type))
                                || !$stable(cross_en));

  // R4: each handshake is counted
  p_req_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready) |=> cnt_req != $past(cnt_req));

  // R3: accepting a stream starts a burst
  p_alloc_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> !alloc_ready);

  // R9: a forbidden crossing invalidates the stream
  p_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ISSUE) && step_cross && !cross_en) |=> !vld_q[$past(tgt_q)]);

  // R7: a matched event is never forwarded to training
  p_no_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_match |-> !miss_to_train);
endmodule

// File: tb/test_pf_stream_table.sv
`timescale 1ns/1ps
module test_pf_stream_table;
  localparam int AW = 16;
  localparam int SW = 8;
  localparam int TW = 2;
  localparam int CW = 16;
  localparam int SU = 3;

  logic          clk, rst_n, cross_en;
  logic          alloc_valid, alloc_ready;
  logic [AW-1:0] alloc_line;
  logic [SW-1:0] alloc_stride;
  logic [TW-1:0] alloc_type;
  logic          evt_valid, evt_ready, evt_kind, evt_match, miss_to_train;
  logic [AW-1:0] evt_line;
  logic          pf_valid, pf_ready;
  logic [AW-1:0] pf_line;
  logic [TW-1:0] pf_type;
  logic [CW-1:0] cnt_alloc, cnt_req, cnt_cross;

  pf_stream_table #(.NSTREAMS(4), .STARTUP(SU), .ADDR_W(AW), .STRIDE_W(SW),
                    .PAGE_BITS(6), .TYPE_W(TW), .TS_W(16), .CNT_W(CW)) i_pf_stream_table (
    .clk(clk), .rst_n(rst_n), .cross_en(cross_en),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_line(alloc_line),
    .alloc_stride(alloc_stride), .alloc_type(alloc_type),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_line(evt_line), .evt_kind(evt_kind),
    .evt_match(evt_match), .miss_to_train(miss_to_train),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line), .pf_type(pf_type),
    .cnt_alloc(cnt_alloc), .cnt_req(cnt_req), .cnt_cross(cnt_cross));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_alloc = 0, exp_req = 0, exp_cross = 0;
  int exp_l[$], exp_t[$], got_l[$], got_t[$];

  task automatic chk(string tag, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // capture every handshake just before the edge that takes it
  always @(negedge clk) begin
    #1.5;
    if (rst_n && pf_valid && pf_ready) begin
      got_l.push_back(int'(pf_line));
      got_t.push_back(int'(pf_type));
    end
  end

  task automatic wait_idle();
    int n = 0;
    do begin
      @(negedge clk);
      #0.2;
      n++;
    end while (!alloc_ready && n < 1000);
    if (!alloc_ready) chk("R3 table never returned idle", 0, 1);
  endtask

  task automatic push_seq(int base, int stride, int n, int typ);
    for (int k = 1; k <= n; k++) begin
      exp_l.push_back((base + k * stride) & 16'hFFFF);
      exp_t.push_back(typ);
    end
    exp_req += n;
  endtask

  task automatic cmp_q(string tag);
    wait_idle();
    chk({tag, " count"}, got_l.size(), exp_l.size());
    for (int i = 0; i < exp_l.size() && i < got_l.size(); i++) begin
      chk({tag, " line"}, got_l[i], exp_l[i]);
      chk({tag, " type"}, got_t[i], exp_t[i]);
    end
    got_l.delete(); got_t.delete(); exp_l.delete(); exp_t.delete();
  endtask

  task automatic cmp_cnt(string tag);
    chk({tag, " cnt_alloc"}, int'(cnt_alloc), exp_alloc);
    chk({tag, " cnt_req"},   int'(cnt_req),   exp_req);
    chk({tag, " cnt_cross"}, int'(cnt_cross), exp_cross);
  endtask

  task automatic do_alloc(int base, int stride, int typ);
    wait_idle();
    #0.2;
    alloc_valid  = 1'b1;
    alloc_line   = AW'(base);
    alloc_stride = SW'(stride);
    alloc_type   = TW'(typ);
    @(negedge clk);
    #0.4;
    alloc_valid = 1'b0;
    exp_alloc++;
  endtask

  task automatic do_evt(int line, int kind, int e_match, int e_fwd, string tag);
    wait_idle();
    #0.2;
    evt_valid = 1'b1;
    evt_line  = AW'(line);
    evt_kind  = kind[0];
    #0.4;
    chk({tag, " evt_ready"}, int'(evt_ready), 1);
    chk({tag, " evt_match"}, int'(evt_match), e_match);
    chk({tag, " miss_to_train"}, int'(miss_to_train), e_fwd);
    @(negedge clk);
    #0.4;
    evt_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cross_en = 1'b0; pf_ready = 1'b1;
    alloc_valid = 1'b0; alloc_line = '0; alloc_stride = '0; alloc_type = '0;
    evt_valid = 1'b0; evt_line = '0; evt_kind = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #0.8;
    chk("R1 pf_valid", int'(pf_valid), 0);
    chk("R1 alloc_ready", int'(alloc_ready), 1);
    cmp_cnt("R1");
    do_evt(16'h0000, 1, 0, 1, "R1 empty table");

    // R3: positive and negative strides, three startup prefetches each
    do_alloc(16'h0100, 2, 1);   push_seq(16'h0100, 2, SU, 1);  cmp_q("R3 A +2");
    do_alloc(16'h0220, -3, 2);  push_seq(16'h0220, -3, SU, 2); cmp_q("R3 B -3");
    do_alloc(16'h0300, 5, 3);   push_seq(16'h0300, 5, SU, 3);  cmp_q("R3 C +5");
    do_alloc(16'h0400, 1, 0);   push_seq(16'h0400, 1, SU, 0);  cmp_q("R3 D +1");
    cmp_cnt("R3 after four");

    // R5/R6: A current 0x106; j=2 via hit, then j=0 via miss
    do_evt(16'h0102, 0, 1, 0, "R5 j=2 hit");  push_seq(16'h0106, 2, 1, 1); cmp_q("R6 A ext1");
    do_evt(16'h0108, 1, 1, 0, "R6 j=0 miss"); push_seq(16'h0108, 2, 1, 1); cmp_q("R6 A ext2");
    // A current 0x10A: j=3 (0x104) is outside the window
    do_evt(16'h0104, 1, 0, 1, "R5 j=3 miss");
    do_evt(16'h0104, 0, 0, 0, "R7 j=3 hit kind");
    cmp_q("R5 no ext");

    // R2: all full, oldest is B; E replaces it. R9: E dies at page edge
    do_alloc(16'h053E, 1, 2);
    push_seq(16'h053E, 1, 1, 2); exp_cross++;
    cmp_q("R9 E burst cut");
    cmp_cnt("R9 E");
    do_evt(16'h0217, 1, 0, 1, "R2 B evicted");
    do_evt(16'h053F, 1, 0, 1, "R9 E dead");

    // R2: F must take the freed slot, so C, D and F all survive
    do_alloc(16'h0600, 1, 1); push_seq(16'h0600, 1, SU, 1); cmp_q("R2 F burst");
    do_evt(16'h0305, 0, 1, 0, "R2 C alive"); push_seq(16'h030F, 5, 1, 3); cmp_q("R6 C ext");
    do_evt(16'h0401, 1, 1, 0, "R2 D alive"); push_seq(16'h0403, 1, 1, 0); cmp_q("R6 D ext");
    do_evt(16'h0603, 0, 1, 0, "R2 F alive"); push_seq(16'h0603, 1, 1, 1); cmp_q("R6 F ext");

    // R8: crossing allowed; oldest now A
    cross_en = 1'b1;
    do_alloc(16'h07FE, 1, 3);
    push_seq(16'h07FE, 1, SU, 3); exp_cross++;
    cmp_q("R8 G across page");
    cmp_cnt("R8 G");
    do_evt(16'h010A, 1, 0, 1, "R2 A evicted");

    // R4: stalled extension on G
    wait_idle();
    pf_ready = 1'b0;
    do_evt(16'h0801, 0, 1, 0, "R4 G hit");
    for (int c = 0; c < 3; c++) begin
      #0.4;
      chk("R4 stall valid", int'(pf_valid), 1);
      chk("R4 stall line", int'(pf_line), 16'h0802);
      chk("R4 stall type", int'(pf_type), 3);
      chk("R4 stall cnt_req", int'(cnt_req), exp_req);
      @(negedge clk);
    end
    #0.4;
    pf_ready = 1'b1;
    push_seq(16'h0801, 1, 1, 3);
    cmp_q("R4 released");
    cmp_cnt("R4");

    // R9: negative stride dropped at page start; C is oldest and replaced
    cross_en = 1'b0;
    do_alloc(16'h0902, -1, 0);
    push_seq(16'h0902, -1, 2, 0); exp_cross++;
    cmp_q("R9 H burst cut");
    cmp_cnt("R9 H");
    do_evt(16'h0900, 1, 0, 1, "R9 H dead");
    do_evt(16'h0314, 1, 0, 1, "R2 C evicted");
    do_evt(16'h0404, 0, 1, 0, "R2 D still alive"); push_seq(16'h0404, 1, 1, 0);
    cmp_q("R6 D ext2");
    cmp_cnt("final");

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule